// File: doc/BRIEF.md
# Log-Depth Tree Magnitude Comparator

This block decides whether one unsigned N-bit operand is strictly larger than a second one. It also reports whether the two operands are identical. The comparison uses a balanced divide-and-conquer network instead of a ripple chain, so the logic depth grows with log2(N) rather than with N.

Each bit position has a single-bit cell that classifies its pair of bits. The cell reports one of three results: A wins, B wins, or the bits match. The bit codes are then merged pairwise, one level at a time, until a single root code remains. A merge node takes the code of its more-significant half. If that half reports a match, the node takes the code of its less-significant half instead.

The operands go through input registers that load on a strobe. The two results are registered again at the output. A caller raises `load` with the operands and reads the flags two rising edges later.

Top module: `mag_compare_tree`

## Requirements
- R1: When `load` is 1 at a rising clock edge, both operand registers capture `op_a` and `op_b`. When `load` is 0, the registers keep their value, and changes on `op_a` and `op_b` have no effect on the outputs.
- R2: The outputs show the result for the registered operands on the rising edge after the capture. So a pair loaded at edge k is reported from edge k+1 onward.
- R3: `a_gt_b` is 1 exactly when the captured A is greater than the captured B, both read as unsigned numbers. It is 0 when A is equal to B or less than B.
- R4: `a_eq_b` is 1 exactly when every bit of the captured A matches the bit in the same position of the captured B.
- R5: `a_gt_b` and `a_eq_b` are never 1 in the same cycle.
- R6: The most significant bit position at which the operands differ sets the result by itself, whatever the lower bits hold. A position with A=1 and B=0 gives greater. A position with A=0 and B=1 gives not greater and not equal. Matching bits pass the decision down to the lower positions.
- R7: `rst_n` is a synchronous reset, active low. While it is 0 at a rising edge, it clears both operand registers and both outputs to 0. On the first edge after release with no load, the cleared operands give `a_eq_b`=1 and `a_gt_b`=0.
- R8: The width `N` is a parameter with default 8. It must be a power of two that is at least 1, and any other value stops elaboration. Instances with N=8, N=16 and N=32 obey R3 and R4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| load | input | 1 | Captures the operands at the next rising edge |
| op_a | input | N | First operand, unsigned |
| op_b | input | N | Second operand, unsigned |
| a_gt_b | output | 1 | Registered: captured A is greater than captured B |
| a_eq_b | output | 1 | Registered: captured A equals captured B |

## Verification
A new load and the output update for the previous load happen on the same clock edge. The operand register is overwritten in the very cycle that the output register samples the tree. The bench loads a new pair on every cycle of the exhaustive 8-bit sweep, so each edge carries both events. A scoreboard queue then checks that every reported flag pair belongs to the pair loaded exactly one edge earlier, and not to the pair being captured at that edge.

// File: rtl/mcmp_pkg.sv
// Shared types for the tree comparator.
// Assumes: nothing beyond standard SystemVerilog.
package mcmp_pkg;

    // Relation code carried on every tree edge: greater flag and equal flag.
    typedef struct packed {
        logic gt;
        logic eq;
    } rel_t;

    // True when v is a power of two that is at least 1.
    function automatic bit is_pow2(input int v);
        return (v >= 1) && ((v & (v - 1)) == 0);
    endfunction

endpackage

// File: rtl/mcmp_leaf.sv
// Single-bit classifier: turns one bit pair into a relation code.
// Assumes: a_bit and b_bit come from the same bit position.
module mcmp_leaf
    import mcmp_pkg::*;
(
    input  logic a_bit,
    input  logic b_bit,
    output rel_t code
);

    // Classify the pair: A wins, B wins, or the bits match.
    always_comb begin
        code.gt = a_bit & ~b_bit;
        code.eq = ~(a_bit ^ b_bit);
    end

endmodule

// File: rtl/mcmp_merge.sv
// Two-input merge node: the upper half decides unless it reports a match.
// Assumes: hi covers more significant bits than lo.
module mcmp_merge
    import mcmp_pkg::*;
(
    input  rel_t hi,
    input  rel_t lo,
    output rel_t y
);

    // Select the lower code only when the upper code says equal.
    always_comb begin
        y = hi.eq ? lo : hi;
    end

endmodule

// File: rtl/mcmp_tree.sv
// Combinational balanced comparison tree of N leaves and N-1 merge nodes.
// Heap layout: node k has children 2k (upper) and 2k+1 (lower); leaves sit
// at N..2N-1 with the most significant bit at index N; the root is node 1.
// Assumes: N is a power of two (checked at the top).
module mcmp_tree
    import mcmp_pkg::*;
#(
    parameter int N = 8
) (
    input  logic [N-1:0] a,
    input  logic [N-1:0] b,
    output rel_t         root
);

    localparam int NODES = 2 * N - 1;

    rel_t node [1:NODES];

    // One classifier per bit position, most significant bit first.
    for (genvar j = 0; j < N; j++) begin : g_leaf
        mcmp_leaf u_leaf (
            .a_bit (a[N-1-j]),
            .b_bit (b[N-1-j]),
            .code  (node[N+j])
        );
    end

    // Merge nodes, log2(N) levels between the leaves and the root.
    for (genvar k = 1; k < N; k++) begin : g_merge
        mcmp_merge u_merge (
            .hi (node[2*k]),
            .lo (node[2*k+1]),
            .y  (node[k])
        );
    end

    assign root = node[1];

endmodule

// File: rtl/mag_compare_tree.sv
// Registered unsigned magnitude comparator built on a log-depth tree.
// Operands load on a strobe; the flags are registered one edge later.
// Assumes: N is a power of two >= 1; the reset is synchronous, active low.
module mag_compare_tree
    import mcmp_pkg::*;
#(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [N-1:0] op_a,
    input  logic [N-1:0] op_b,
    output logic         a_gt_b,
    output logic         a_eq_b
);

    // Stop elaboration for widths the tree cannot split evenly.
    if (!is_pow2(N)) begin : g_bad_width
        $error("mag_compare_tree: N must be a power of two >= 1");
    end

    logic [N-1:0] a_q;
    logic [N-1:0] b_q;
    rel_t         root;

    // Operand capture on the load strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_q <= '0;
            b_q <= '0;
        end else if (load) begin
            a_q <= op_a;
            b_q <= op_b;
        end
    end

    mcmp_tree #(.N(N)) u_tree (
        .a    (a_q),
        .b    (b_q),
        .root (root)
    );

    // Output register for the root code.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_gt_b <= 1'b0;
            a_eq_b <= 1'b0;
        end else begin
            a_gt_b <= root.gt;
            a_eq_b <= root.eq;
        end
    end

    // R1: a load edge stores the presented operands
    p_capture_r1: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (a_q == $past(op_a)) && (b_q == $past(op_b)));

    // R1: without load the operand registers hold
    p_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(a_q) && $stable(b_q));

    // R3: greater flag matches the operator on last cycle's operands
    p_gt_ref_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (a_gt_b == ($past(a_q) > $past(b_q))));

    // R4: equal flag matches full equality of last cycle's operands
    p_eq_ref_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (a_eq_b == ($past(a_q) == $past(b_q))));

    // R5: the two flags are mutually exclusive
    p_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({a_gt_b, a_eq_b}));

endmodule

// File: tb/sim_mag_compare_tree.sv
`timescale 1ns/1ps
// Scoreboard bench: the driver queues expected flags per load, the monitor
// pops them as the outputs settle one edge after capture.
module sim_mag_compare_tree;

    localparam real CYC = 8.0;

    logic clk = 1'b0;
    logic rst_n;
    logic load;
    logic [7:0]  a8,  b8;
    logic [15:0] a16, b16;
    logic [31:0] a32, b32;
    logic gt8, eq8, gt16, eq16, gt32, eq32;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    logic [1:0] q8  [$];
    logic [1:0] q16 [$];
    logic [1:0] q32 [$];
    logic vld1, vld2;

    always #(CYC/2) clk = ~clk;

    mag_compare_tree #(.N(8)) u0 (
        .clk(clk), .rst_n(rst_n), .load(load), .op_a(a8), .op_b(b8),
        .a_gt_b(gt8), .a_eq_b(eq8));
    mag_compare_tree #(.N(16)) u1 (
        .clk(clk), .rst_n(rst_n), .load(load), .op_a(a16), .op_b(b16),
        .a_gt_b(gt16), .a_eq_b(eq16));
    mag_compare_tree #(.N(32)) u2 (
        .clk(clk), .rst_n(rst_n), .load(load), .op_a(a32), .op_b(b32),
        .a_gt_b(gt32), .a_eq_b(eq32));

    // Generic check reporter.
    task automatic check(input string req, input logic [1:0] act,
                         input logic [1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: {gt,eq} actual=%b expected=%b", req, act, exp);
        end
    endtask

    // Driver: present one set of operands with load and queue expectations.
    task automatic drive(input logic [7:0] x8, input logic [7:0] y8,
                         input logic [15:0] x16, input logic [15:0] y16,
                         input logic [31:0] x32, input logic [31:0] y32);
        @(negedge clk);
        load = 1'b1;
        a8 = x8;   b8 = y8;
        a16 = x16; b16 = y16;
        a32 = x32; b32 = y32;
        q8.push_back({x8 > y8, x8 == y8});
        q16.push_back({x16 > y16, x16 == y16});
        q32.push_back({x32 > y32, x32 == y32});
    endtask

    // Tracks which edges carry a result: load edge, then one more edge.
    always @(posedge clk) begin
        vld1 <= rst_n && load;
        vld2 <= rst_n && vld1;
    end

    // Monitor: compare settled outputs against the queue heads (R2, R3, R4).
    always @(negedge clk) begin
        if (vld2 === 1'b1) begin
            if (q8.size() == 0) begin
                checks++; errors++;
                $display("FAIL R2: output without queued item actual=1 expected=0");
            end else begin
                check("R3/R4/R2 N=8",  {gt8, eq8},   q8.pop_front());
                check("R8 N=16",       {gt16, eq16}, q16.pop_front());
                check("R8 N=32",       {gt32, eq32}, q32.pop_front());
            end
        end
    end

    // Random 32-bit value with a chance of sharing most upper bits.
    function automatic logic [31:0] near(input logic [31:0] v);
        int sel = $urandom % 4;
        if (sel == 0) return v;
        if (sel == 1) return v ^ (32'd1 << ($urandom % 32));
        return $urandom;
    endfunction

    task automatic drive8(input logic [7:0] x, input logic [7:0] y);
        logic [31:0] r = $urandom;
        logic [31:0] s = near(r);
        drive(x, y, r[15:0], s[15:0], r, s);
    endtask

    initial begin
        vld1 = 1'b0; vld2 = 1'b0;
        rst_n = 1'b0; load = 1'b0;
        a8 = '0; b8 = '0; a16 = '0; b16 = '0; a32 = '0; b32 = '0;
        repeat (3) @(negedge clk);
        // R7: outputs cleared while reset is held
        check("R7 reset value", {gt8, eq8}, 2'b00);
        rst_n = 1'b1;
        @(negedge clk);
        // R7: cleared operands compare equal one edge after release
        check("R7 after release", {gt8, eq8}, 2'b01);

        // R6: the top differing bit decides
        drive8(8'h80, 8'h7F);
        drive8(8'h7F, 8'h80);
        drive8(8'hA5, 8'hA4);
        drive8(8'hA4, 8'hA5);
        drive8(8'h55, 8'h55);
        drive8(8'hFF, 8'h00);
        drive8(8'h00, 8'hFF);
        drive8(8'h01, 8'h00);

        // R3/R4: every 8-bit pair, one load per cycle
        for (int i = 0; i < 256; i++) begin
            for (int j = 0; j < 256; j++) begin
                drive8(i[7:0], j[7:0]);
            end
        end

        @(negedge clk);
        load = 1'b0;
        repeat (3) @(negedge clk);
        // R1: last pair was (255,255): equal; changing inputs must not matter
        a8 = 8'hFF; b8 = 8'h00;
        repeat (3) @(negedge clk);
        check("R1 hold with load low", {gt8, eq8}, 2'b01);
        a8 = 8'h00; b8 = 8'h80;
        repeat (2) @(negedge clk);
        check("R1 hold second change", {gt8, eq8}, 2'b01);

        // R7: reset mid-operation clears outputs, then cleared operands
        drive8(8'hC0, 8'h10);
        @(negedge clk);
        load = 1'b0;
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check("R7 mid-run clear", {gt8, eq8}, 2'b00);
        q8.delete(); q16.delete(); q32.delete();
        rst_n = 1'b1;
        @(negedge clk);
        check("R7 operands cleared", {gt8, eq8}, 2'b01);

        // R8: queues must be drained
        check("R2 queue drained", {1'b0, q8.size() == 0}, 2'b01);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        #(CYC * 150000);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule